// File: doc/BRIEF.md
# Cycle-Stealing Expansion Bus Write Master

This block lets an expansion-port device take over the system bus of a 6502-family machine that shares that bus with a video controller. It accepts write requests, each an address and a data byte, from a local valid/ready interface. It halts the CPU with the active-low DMA line and then places each write on the bus during the half of the two-phase system clock (PHI2) that the CPU normally uses. The bus-available (BA) line is watched so that the video controller's stolen cycles are respected.

The block runs on a fast local clock. PHI2 and BA reach it through two-flop synchronizers, and the PHI2 edges are taken from the synchronized copy. In every PHI2-low half the master hands the bus back, because the video controller fetches and refreshes memory there. While BA is low it starts no write. A write that BA interrupts is withdrawn and repeated later. An optional hold input keeps the CPU halted between bursts.

Top module: `exp_dma_master`

## Requirements
- R1: After reset, `dma_n` is 1, `bus_oe` is 0, `bus_rw_n` is 1 and `req_ready` is 1 (with BA high).
- R2: One request is held at a time. It is taken on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a taken request is not yet written, and also while BA is low.
- R3: `dma_n` changes only on a PHI2 falling edge. It goes low only when BA is high and a request is pending or `hold` is 1.
- R4: At the first PHI2 rising edge where `dma_n` is low, BA is high and a request is pending, the block sets `bus_oe`=1 and `bus_rw_n`=0 and drives the request's address and data. It holds them stable until the PHI2 falling edge, which retires the request.
- R5: Bus outputs and `dma_n` react exactly three local clock edges after the PHI2/BA input change: two synchronizer stages plus one state register. `bus_oe` is 1 only when the delayed PHI2 and BA are both high.
- R6: If BA falls during a write slot, the slot ends on the next local cycle. The request stays pending and is written in a later PHI2-high slot after BA returns high.
- R7: If BA falls in the same local cycle that the PHI2 falling edge is seen, the write counts as complete and is not repeated.
- R8: On a PHI2 falling edge with no request pending after that cycle and `hold` 0, `dma_n` returns to 1.
- R9: While `hold` is 1, `dma_n` stays low once asserted, even with no request pending.
- R10: Outside a write slot, `bus_oe` is 0 and `bus_rw_n` is 1.
- R11: Requests appear on the bus in the order they were taken, and each completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than PHI2 |
| rst_n | input | 1 | Active-low reset |
| phi2_i | input | 1 | System clock PHI2, asynchronous |
| ba_i | input | 1 | Bus-available line, asynchronous, high = CPU slots usable |
| hold_i | input | 1 | Keep the CPU halted between bursts |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 16 | Write address |
| req_data | input | 8 | Write data |
| dma_n | output | 1 | Active-low CPU halt |
| bus_oe | output | 1 | Enable for the address, data and R/W drivers |
| bus_addr | output | 16 | Address to drive |
| bus_data | output | 8 | Data to drive |
| bus_rw_n | output | 1 | Read/not-write, 0 during a write slot |

## Verification
Two events can fall in the same local cycle: completion of a slot at the PHI2 falling edge, and the abort caused by BA going low. The bench waits for a live slot and then drops BA in the same timestep as PHI2 falls, so both reach the synchronizers together. It then requires exactly one completed write and no later repeat. A sweep of BA drop offsets inside the slot checks the other side: each such drop must abort the write and lead to one retried completion.

// File: rtl/exp_dma_pkg.sv
package exp_dma_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef struct packed {
        logic              full;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_slot_t;

    typedef struct packed {
        logic dma_n;
        logic active;
    } ctl_state_t;
endpackage

// File: rtl/exp_dma_sync.sv
module exp_dma_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    input  logic [WIDTH-1:0] reset_val,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] chain_d [DEPTH];
    logic [WIDTH-1:0] chain_q [DEPTH];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= reset_val;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/exp_dma_reqbuf.sv
module exp_dma_reqbuf
    import exp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              allow_i,
    input  logic              pop_i,
    output logic              in_ready,
    output logic              take_o,
    output req_slot_t         slot_o
);
    req_slot_t slot_d, slot_q;

    always_comb begin
        slot_d   = slot_q;
        in_ready = !slot_q.full && allow_i;
        take_o   = in_valid && in_ready;
        if (pop_i) slot_d.full = 1'b0;
        if (take_o) begin
            slot_d.full = 1'b1;
            slot_d.addr = in_addr;
            slot_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot_o = slot_q;

    // R2
    take_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> slot_q.full);

    // R11
    held_entry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.full && $past(slot_q.full)) |-> ($stable(slot_q.addr) && $stable(slot_q.data)));
endmodule

// File: rtl/exp_dma_master.sv
module exp_dma_master
    import exp_dma_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2_i,
    input  logic              ba_i,
    input  logic              hold_i,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              dma_n,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_rw_n
);
    localparam int SIG_W = 2;
    localparam int IDX_PHI = 0;
    localparam int IDX_BA  = 1;

    logic [SIG_W-1:0] lvl, rise, fall;
    logic phi2_rise, phi2_fall, ba_s, ba_fall, ba_rise;
    logic pop, take, pending_next;
    req_slot_t  slot;
    ctl_state_t st_d, st_q;

    exp_dma_sync #(.WIDTH(SIG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_i   ({ba_i, phi2_i}),
        .reset_val (2'b10),
        .lvl_o     (lvl),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    assign phi2_rise = rise[IDX_PHI];
    assign phi2_fall = fall[IDX_PHI];
    assign ba_s      = lvl[IDX_BA];
    assign ba_fall   = fall[IDX_BA];
    assign ba_rise   = rise[IDX_BA];

    exp_dma_reqbuf u_reqbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_addr  (req_addr),
        .in_data  (req_data),
        .allow_i  (ba_s),
        .pop_i    (pop),
        .in_ready (req_ready),
        .take_o   (take),
        .slot_o   (slot)
    );

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        // slot end: the PHI2 fall completes, otherwise a low BA withdraws
        if (st_q.active) begin
            if (phi2_fall) begin
                st_d.active = 1'b0;
                pop         = 1'b1;
            end else if (!ba_s) begin
                st_d.active = 1'b0;
            end
        end else if (phi2_rise && !st_q.dma_n && ba_s && slot.full) begin
            st_d.active = 1'b1;
        end
        pending_next = (slot.full && !pop) || take;
        // CPU halt line only moves on a PHI2 falling edge
        if (phi2_fall) begin
            if (!st_q.dma_n) begin
                if (!pending_next && !hold_i) st_d.dma_n = 1'b1;
            end else if ((pending_next || hold_i) && ba_s) begin
                st_d.dma_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dma_n  <= 1'b1;
            st_q.active <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dma_n    = st_q.dma_n;
    assign bus_oe   = st_q.active;
    assign bus_rw_n = !st_q.active;
    assign bus_addr = slot.addr;
    assign bus_data = slot.data;

    // R3
    dma_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.dma_n) |-> $past(phi2_fall));

    // R3
    dma_assert_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.dma_n) |-> $past(ba_s));

    // R4
    slot_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (!st_q.dma_n && slot.full));

    // R4
    slot_start_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> ($past(ba_s) && $past(phi2_rise)));

    // R6
    ba_drop_ends_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_fall && !phi2_fall) |=> !st_q.active);

    // R6
    no_slot_at_ba_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_rise |-> !st_q.active);

    // R11
    retire_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slot.full) |-> ($past(st_q.active) && $past(phi2_fall)));
endmodule

// File: tb/exp_dma_master_bench.sv
module exp_dma_master_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0, ba = 1'b1, hold = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_ready, dma_n, bus_oe, bus_rw_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_data;

    exp_dma_master u_exp_dma_master (
        .clk(clk), .rst_n(rst_n), .phi2_i(phi2), .ba_i(ba), .hold_i(hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .dma_n(dma_n), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_rw_n(bus_rw_n)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // PHI2 model: 16 local clocks per period, 8 high
    int pc = 0;
    always @(negedge clk) begin
        pc   <= (pc == 15) ? 0 : pc + 1;
        phi2 <= (pc < 8);
    end

    // three-edge delayed copies of the inputs (R5)
    logic ph0 = 0, ph1 = 0, ph2 = 0, ph3 = 0, bb0 = 1, bb1 = 1, bb2 = 1;
    always @(posedge clk) begin
        {ph3, ph2, ph1, ph0} <= {ph2, ph1, ph0, phi2};
        {bb2, bb1, bb0}      <= {bb1, bb0, ba};
    end

    logic [15:0] exp_addr [64];
    logic [7:0]  exp_data [64];
    int wr_idx = 0, rd_idx = 0, n_done = 0, n_abort = 0;
    logic oe_prev = 0, dma_prev = 1;
    logic [15:0] last_a;
    logic [7:0]  last_d;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_oe) begin
                if (!(ph2 && bb2)) chk(0, "R5", "bus_oe outside PHI2-high/BA-high", 1, 0);
                if (bus_rw_n) chk(0, "R4", "rw_n during slot", 1, 0);
                last_a = bus_addr;
                last_d = bus_data;
            end else if (!bus_rw_n) begin
                chk(0, "R10", "rw_n low outside slot", 0, 1);
            end
            if (oe_prev && !bus_oe) begin
                if (!ph2) begin
                    chk(last_a == exp_addr[rd_idx], "R11", "written address", last_a, exp_addr[rd_idx]);
                    chk(last_d == exp_data[rd_idx], "R11", "written data", last_d, exp_data[rd_idx]);
                    rd_idx++;
                    n_done++;
                end else begin
                    chk(!bb2, "R6", "slot ended with BA high", bb2, 0);
                    n_abort++;
                end
            end
            if (dma_n != dma_prev) begin
                chk(!ph2 && ph3, "R3", "dma_n moved off a PHI2 fall", {ph3, ph2}, 2);
                if (!dma_n) chk(bb2, "R3", "dma_n asserted with BA low", bb2, 1);
            end
            oe_prev  = bus_oe;
            dma_prev = dma_n;
        end
    end

    task automatic push(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = a; req_data = d;
        exp_addr[wr_idx] = a; exp_data[wr_idx] = d; wr_idx++;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R2", "ready while entry pending", req_ready, 0);
    endtask

    task automatic wait_done(input int n);
        for (int g = 0; g < 5000 && n_done < n; g++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : main
        int base, ab, lat;
        idle(5);
        chk(dma_n == 1, "R1", "reset dma_n", dma_n, 1);
        chk(bus_oe == 0, "R1", "reset bus_oe", bus_oe, 0);
        chk(bus_rw_n == 1, "R1", "reset rw_n", bus_rw_n, 1);
        rst_n = 1;
        idle(4);
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);

        // sweep of addresses and data, BA high throughout (R4, R11)
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a = (i == 0) ? 16'h0000 : (i == 15) ? 16'hFFFF : 16'(i * 16'h0AB3 + 7);
            push(a, 8'(i * 37 + 1));
        end
        wait_done(16);
        chk(n_done == 16, "R11", "sweep completions", n_done, 16);
        idle(32);
        chk(dma_n == 1, "R8", "released after empty queue", dma_n, 1);
        chk(bus_oe == 0, "R10", "idle bus_oe", bus_oe, 0);

        // ready with BA low (R2)
        @(negedge clk); ba = 0;
        idle(4);
        chk(req_ready == 0, "R2", "ready with BA low", req_ready, 0);
        ba = 1;
        idle(4);
        chk(req_ready == 1, "R2", "ready after BA back", req_ready, 1);

        // abort sweep over drop offsets inside the slot (R6)
        for (int off = 0; off < 5; off++) begin
            base = n_done; ab = n_abort;
            push(16'h4000 + 16'(off), 8'hC0 + 8'(off));
            wait (bus_oe);
            idle(off + 1);
            ba = 0;
            idle(40);
            chk(n_done == base, "R6", "no completion while BA low", n_done, base);
            chk(n_abort == ab + 1, "R6", "abort seen", n_abort, ab + 1);
            chk(bus_oe == 0, "R6", "bus released while BA low", bus_oe, 0);
            ba = 1;
            wait_done(base + 1);
            chk(n_done == base + 1, "R6", "retried write completes", n_done, base + 1);
            idle(20);
        end

        // BA falls with the PHI2 fall (R7)
        base = n_done; ab = n_abort;
        push(16'hBEEF, 8'h5A);
        wait (bus_oe);
        @(negedge phi2);
        ba = 0;
        idle(40);
        chk(n_done == base + 1, "R7", "simultaneous fall completes", n_done, base + 1);
        chk(n_abort == ab, "R7", "no abort on simultaneous fall", n_abort, ab);
        ba = 1;
        idle(48);
        chk(n_done == base + 1, "R7", "no repeat of completed write", n_done, base + 1);

        // hold and latency (R9, R5)
        hold = 1;
        push(16'h1234, 8'h11);
        wait_done(n_done + 1);
        push(16'h2345, 8'h22);
        @(posedge phi2);
        lat = 0;
        while (!bus_oe && lat < 20) begin @(posedge clk); #1; lat++; end
        chk(lat == 3, "R5", "slot start latency", lat, 3);
        wait_done(rd_idx + 1);
        idle(48);
        chk(dma_n == 0, "R9", "hold keeps CPU halted", dma_n, 0);
        hold = 0;
        idle(40);
        chk(dma_n == 1, "R8", "release after hold drops", dma_n, 1);

        // no DMA assertion while BA low (R3)
        @(posedge phi2);
        base = n_done;
        push(16'h7777, 8'h77);
        @(negedge clk); ba = 0;
        idle(48);
        chk(dma_n == 1, "R3", "no assertion with BA low", dma_n, 1);
        chk(n_done == base, "R3", "no write with BA low", n_done, base);
        ba = 1;
        wait_done(base + 1);
        chk(n_done == base + 1, "R3", "write after BA returns", n_done, base + 1);
        idle(40);
        chk(dma_n == 1, "R8", "final release", dma_n, 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule